// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page address for one request at a time. Each request carries an access kind (load, store or instruction fetch) and a 2-bit privilege index. Index 3 selects physical mode. A sign-extension check comes first. Negative addresses in one fixed window then map straight through a kernel superpage. Every other address walks three levels of 8-byte page table entries, which the block fetches through a read port. The root table address `ptbr` is sampled when the request is accepted.

The result is either a page address with a read/write/execute permission set, or a fault code. On a fault the block also returns trap arguments: the faulting address and an access code. Pages are 8 KB (`PAGE_BITS` = 13), each table index is 10 bits and 43 virtual address bits are implemented.

The request, the result and the memory read request all use valid/ready.
- A request is taken only on a cycle where `req_valid` and `req_ready` are both high.
- Once `rsp_valid` or `mem_req_valid` is raised, it stays high and its payload stays stable until ready is seen.
- Memory read data has no back-pressure. It is taken on the one cycle where `mem_rsp_valid` is high while a read is outstanding.

Top module: `ptw_walker`

## Requirements
- R1: With privilege index 3 the result is `rsp_paddr` = virtual address and `rsp_prot` = 3'b111 (bit0 read, bit1 write, bit2 execute). No fault is raised and no memory read is made.
- R2: If address bits 63:43 are not all equal, the result is a fault with code 1 (access violation) and no memory read is made.
- R3: If bit 63 is set and bits 42:41 equal 2'b10, privilege 0 gets a page address made of bits 39:0 of the address, with address bit 40 placed at bit 43 and all other bits zero. `rsp_prot` is 3'b111 and no memory read is made.
- R4: Privilege 1 or 2 in the superpage window gets fault code 1 with no memory read.
- R5: The walk reads first at `ptbr` + 8·VA[42:33], then at base + 8·VA[32:23], then at base + 8·VA[22:13]. Each next base is entry[63:32] shifted left by 13.
- R6: At the first two levels, entry bit 0 (valid) clear gives fault code 0 (not valid). Otherwise, bit 8 (kernel read) clear gives code 1. Either fault ends the walk at once.
- R7: A last-level entry with bit 0 clear gives fault code 0.
- R8: At the last level, read and execute rights come from entry bit 8+priv and write right from bit 12+priv. Load needs read, store needs write and fetch needs execute (access code 0, 1, and 2 or 3). Without the needed right the result is code 1.
- R9: Entry bits 1, 2 and 3 remove read, write and execute rights respectively. If the needed right is removed, the code is 3 for a fetch, 4 for a store and 2 for a load.
- R10: A successful walk returns fault 0, page address entry[63:32]<<13, and the masked rights as `rsp_prot`.
- R11: `rsp_trap_va` is the request address. `rsp_trap_acc` is 0 for load, 1 for store and all ones for fetch. On a fault, `rsp_paddr` and `rsp_prot` are zero.
- R12: The block takes one request at a time. `req_ready` is high only when idle, `busy` is high from acceptance until the result handshake, and the result is held while `rsp_ready` is low.
- R13: At most one memory read is outstanding, and `mem_req_addr` is held while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr | input | 64 | Root page table physical address |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access: 0 load, 1 store, 2/3 fetch |
| req_priv | input | 2 | Privilege index, 3 = physical |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read back |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 3 | Fault code |
| rsp_paddr | output | 64 | Physical page address |
| rsp_prot | output | 3 | Granted rights: bit0 read, bit1 write, bit2 execute |
| rsp_trap_va | output | 64 | Faulting virtual address |
| rsp_trap_acc | output | 64 | Access code trap argument |

## Verification
Some rules are checked by assertions on every cycle. These are the handshake rules: the result and the read request stay stable under back-pressure, only one read is in flight, the level counter stays in range, a fault carries zero rights, and `busy` rises only after an accepted request. The translation itself can only be shown by the bench's scenarios, which compare results with a reference walk over the bench's own table memory. That covers the read addresses and their count, the superpage bit move, the order in which faults take precedence across levels, the privilege-shifted permission bits and the fault-on codes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam logic [2:0] FLT_TNV = 3'd0;
  localparam logic [2:0] FLT_ACV = 3'd1;
  localparam logic [2:0] FLT_FOR = 3'd2;
  localparam logic [2:0] FLT_FOE = 3'd3;
  localparam logic [2:0] FLT_FOW = 3'd4;

  localparam int PTE_VALID_POS = 0;
  localparam int PTE_FOX_LO    = 1;
  localparam int PTE_RD_BASE   = 8;
  localparam int PTE_WR_BASE   = 12;

  localparam logic [1:0] PRIV_KERNEL = 2'd0;
  localparam logic [1:0] PRIV_PHYS   = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic        fault;
    logic [2:0]  code;
    logic [2:0]  prot;
    logic [63:0] paddr;
  } xlat_res_t;
endpackage

// File: rtl/ptw_classify.sv
module ptw_classify
  import ptw_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int SP_SEL_LO = 41,
  parameter int SP_KEEP   = 40,
  parameter int SP_MOVE   = 43
) (
  input  logic [63:0] va,
  input  logic [1:0]  priv,
  output logic        shortcut,
  output xlat_res_t   res
);
  localparam int SIGN_W = 64 - VA_BITS;

  logic sign_ok, in_sp;
  assign sign_ok = (va[63:VA_BITS] == {SIGN_W{va[63]}});
  assign in_sp   = va[63] && (va[SP_SEL_LO+1:SP_SEL_LO] == 2'b10);

  always_comb begin
    shortcut  = 1'b1;
    res       = '0;
    if (priv == PRIV_PHYS) begin
      res.paddr = va;
      res.prot  = 3'b111;
    end else if (!sign_ok) begin
      res.fault = 1'b1;
      res.code  = FLT_ACV;
    end else if (in_sp) begin
      if (priv != PRIV_KERNEL) begin
        res.fault = 1'b1;
        res.code  = FLT_ACV;
      end else begin
        res.paddr[SP_KEEP-1:0] = va[SP_KEEP-1:0];
        res.paddr[SP_MOVE]     = va[SP_KEEP];
        res.prot               = 3'b111;
      end
    end else begin
      shortcut = 1'b0;
    end
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
  import ptw_pkg::*;
#(
  parameter int PAGE_BITS = 13
) (
  input  logic [63:0] pte,
  input  logic [1:0]  priv,
  input  logic [2:0]  need,
  output xlat_res_t   res
);
  logic [5:0] rd_pos, wr_pos;
  logic       rd_ok, wr_ok;
  logic [2:0] granted, masked;
  logic [63:0] frame;

  assign rd_pos  = 6'(PTE_RD_BASE) + {4'b0, priv};
  assign wr_pos  = 6'(PTE_WR_BASE) + {4'b0, priv};
  assign rd_ok   = pte[rd_pos];
  assign wr_ok   = pte[wr_pos];
  assign granted = {rd_ok, wr_ok, rd_ok};
  assign masked  = granted & ~pte[PTE_FOX_LO+2:PTE_FOX_LO];
  assign frame   = 64'(pte[63:32]) << PAGE_BITS;

  always_comb begin
    res = '0;
    if (!pte[PTE_VALID_POS]) begin
      res.fault = 1'b1;
      res.code  = FLT_TNV;
    end else if ((granted & need) == 3'b000) begin
      res.fault = 1'b1;
      res.code  = FLT_ACV;
    end else if ((masked & need) == 3'b000) begin
      res.fault = 1'b1;
      res.code  = need[2] ? FLT_FOE : (need[1] ? FLT_FOW : FLT_FOR);
    end else begin
      res.prot  = masked;
      res.paddr = frame;
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3,
  parameter int VA_BITS   = 43
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] ptbr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic [1:0]  req_priv,
  output logic        busy,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic [2:0]  rsp_code,
  output logic [63:0] rsp_paddr,
  output logic [2:0]  rsp_prot,
  output logic [63:0] rsp_trap_va,
  output logic [63:0] rsp_trap_acc
);
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_SH  = 3;
  localparam int PAD_W   = 64 - IDX_BITS - ENT_SH;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e       state_q;
  logic [63:0]       va_q, base_q;
  logic [1:0]        acc_q, priv_q;
  logic [LVL_W-1:0]  lvl_q;
  xlat_res_t         res_q;

  logic              cls_short;
  xlat_res_t         cls_res, leaf_res;
  logic [2:0]        need;
  logic [IDX_BITS-1:0] lvl_idx [LEVELS];
  logic [IDX_BITS-1:0] cur_idx;
  logic [63:0]       next_base;

  ptw_classify #(.VA_BITS(VA_BITS)) u_cls (
    .va(req_vaddr), .priv(req_priv), .shortcut(cls_short), .res(cls_res)
  );

  ptw_leaf #(.PAGE_BITS(PAGE_BITS)) u_leaf (
    .pte(mem_rsp_data), .priv(priv_q), .need(need), .res(leaf_res)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign lvl_idx[g] = va_q[PAGE_BITS + IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
  end

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < LEVELS; i++)
      if (lvl_q == LVL_W'(i)) cur_idx = lvl_idx[i];
  end

  assign need      = (acc_q == 2'd0) ? 3'b001 : ((acc_q == 2'd1) ? 3'b010 : 3'b100);
  assign next_base = 64'(mem_rsp_data[63:32]) << PAGE_BITS;

  assign req_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_READ);
  assign mem_req_addr  = base_q + {{PAD_W{1'b0}}, cur_idx, {ENT_SH{1'b0}}};
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_fault     = res_q.fault;
  assign rsp_code      = res_q.code;
  assign rsp_paddr     = res_q.paddr;
  assign rsp_prot      = res_q.prot;
  assign rsp_trap_va   = va_q;
  assign rsp_trap_acc  = (acc_q == 2'd0) ? 64'd0 : ((acc_q == 2'd1) ? 64'd1 : '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      acc_q   <= '0;
      priv_q  <= '0;
      lvl_q   <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_acc;
          priv_q <= req_priv;
          base_q <= ptbr;
          lvl_q  <= '0;
          res_q  <= cls_res;
          state_q <= cls_short ? ST_DONE : ST_READ;
        end
        ST_READ: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (lvl_q == LAST_LVL) begin
            res_q   <= leaf_res;
            state_q <= ST_DONE;
          end else if (!mem_rsp_data[PTE_VALID_POS]) begin
            res_q   <= '{fault: 1'b1, code: FLT_TNV, prot: 3'b0, paddr: 64'd0};
            state_q <= ST_DONE;
          end else if (!mem_rsp_data[PTE_RD_BASE]) begin
            res_q   <= '{fault: 1'b1, code: FLT_ACV, prot: 3'b0, paddr: 64'd0};
            state_q <= ST_DONE;
          end else begin
            base_q  <= next_base;
            lvl_q   <= lvl_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SHORTCUT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cls_short) |=> (rsp_valid && !mem_req_valid)); // R1

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lvl_q <= LAST_LVL)); // R5

  AST_FAULT_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_prot == 3'b000 && rsp_paddr == 64'd0)); // R11

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R12

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_code)
                                   && $stable(rsp_fault) && $stable(rsp_prot))); // R12

  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R13

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R13
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ptbr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic [1:0]  req_priv = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [2:0]  rsp_code;
  logic [63:0] rsp_paddr;
  logic [2:0]  rsp_prot;
  logic [63:0] rsp_trap_va;
  logic [63:0] rsp_trap_acc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit all_done = 0;

  logic [63:0] pmem [logic [63:0]];

  logic        e_fault;
  logic [2:0]  e_code;
  logic [63:0] e_paddr;
  logic [2:0]  e_prot;
  logic [63:0] e_tacc;
  int          e_nrd;
  logic [63:0] e_addr [3];

  localparam logic [15:0] V   = 16'h0001;
  localparam logic [15:0] KRE = 16'h0100;
  localparam logic [15:0] ERE = 16'h0200;
  localparam logic [15:0] KWE = 16'h1000;
  localparam logic [15:0] FOR = 16'h0002;
  localparam logic [15:0] FOW = 16'h0004;
  localparam logic [15:0] FOE = 16'h0008;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_priv(req_priv), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .rsp_prot(rsp_prot), .rsp_trap_va(rsp_trap_va), .rsp_trap_acc(rsp_trap_acc)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !all_done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R12: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return pmem.exists(a) ? pmem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] mk(input logic [31:0] frame, input logic [15:0] low);
    return {frame, 16'h0, low};
  endfunction

  // Reference walk built from the requirement text
  function automatic void model(input logic [63:0] va, input logic [1:0] acc,
                                input logic [1:0] priv, input logic [63:0] root);
    logic [63:0] base, pte;
    logic [2:0]  need, gr, mk3;
    e_fault = 0; e_code = 0; e_paddr = 0; e_prot = 0; e_nrd = 0;
    e_tacc  = (acc == 0) ? 64'd0 : (acc == 1) ? 64'd1 : {64{1'b1}};
    need    = (acc == 0) ? 3'b001 : (acc == 1) ? 3'b010 : 3'b100;
    if (priv == 2'd3) begin
      e_paddr = va; e_prot = 3'b111;
    end else if (va[63:43] != {21{va[63]}}) begin
      e_fault = 1; e_code = 1;
    end else if (va[63] && va[42:41] == 2'b10) begin
      if (priv != 0) begin e_fault = 1; e_code = 1; end
      else begin
        e_paddr = 0; e_paddr[39:0] = va[39:0]; e_paddr[43] = va[40]; e_prot = 3'b111;
      end
    end else begin
      base = root;
      for (int l = 0; l < 3; l++) begin
        e_addr[l] = base + {51'd0, va[13 + 10*(2-l) +: 10], 3'b000};
        e_nrd = l + 1;
        pte = rd(e_addr[l]);
        if (l < 2) begin
          if (!pte[0]) begin e_fault = 1; e_code = 0; return; end
          if (!pte[8]) begin e_fault = 1; e_code = 1; return; end
          base = {32'd0, pte[63:32]} << 13;
        end else begin
          if (!pte[0]) begin e_fault = 1; e_code = 0; return; end
          gr = {pte[8 + priv], pte[12 + priv], pte[8 + priv]};
          if ((gr & need) == 0) begin e_fault = 1; e_code = 1; return; end
          mk3 = gr & ~pte[3:1];
          if ((mk3 & need) == 0) begin
            e_fault = 1; e_code = need[2] ? 3'd3 : need[1] ? 3'd4 : 3'd2; return;
          end
          e_prot = mk3; e_paddr = {32'd0, pte[63:32]} << 13;
        end
      end
    end
  endfunction

  task automatic set_walk(input logic [63:0] va, input logic [63:0] root,
                          input logic [63:0] p1, input logic [63:0] p2, input logic [63:0] p3);
    logic [63:0] a;
    a = root + {51'd0, va[42:33], 3'b000};             pmem[a] = p1;
    a = ({32'd0, p1[63:32]} << 13) + {51'd0, va[32:23], 3'b000}; pmem[a] = p2;
    a = ({32'd0, p2[63:32]} << 13) + {51'd0, va[22:13], 3'b000}; pmem[a] = p3;
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] priv,
                     input logic [63:0] root, input int rdly, input string tag);
    int nrd = 0;
    bit pend = 0, fin = 0, addr_ok = 1;
    logic [63:0] pa = '0;
    model(va, acc, priv, root);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc; req_priv = priv; ptbr = root;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(busy && !req_ready, "R12 busy after accept", {62'd0, busy, req_ready}, 64'd2);
    for (int c = 0; c < 100 && !fin; c++) begin
      mem_rsp_valid = 0;
      if (pend) begin
        mem_rsp_valid = 1; mem_rsp_data = rd(pa); pend = 0;
      end else begin
        mem_req_ready = ($urandom % 4) != 0;
        if (mem_req_valid && mem_req_ready) begin
          if (nrd < 3 && mem_req_addr != e_addr[nrd]) addr_ok = 0;
          nrd++; pend = 1; pa = mem_req_addr;
        end
      end
      if (rsp_valid) begin
        mem_rsp_valid = 0;
        repeat (rdly) @(negedge clk);
        check({rsp_fault, rsp_code} == {e_fault, e_code}, tag,
              {60'd0, rsp_fault, rsp_code}, {60'd0, e_fault, e_code});
        check(rsp_paddr == e_paddr, "R10 paddr", rsp_paddr, e_paddr);
        check(rsp_prot == e_prot, "R9 prot", {61'd0, rsp_prot}, {61'd0, e_prot});
        check(rsp_trap_va == va && rsp_trap_acc == e_tacc, "R11 trap args", rsp_trap_acc, e_tacc);
        check(nrd == e_nrd && addr_ok, "R5 read count and addresses", 64'(nrd), 64'(e_nrd));
        rsp_ready = 1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 0;
        fin = 1;
      end else begin
        @(negedge clk);
      end
    end
    mem_rsp_valid = 0;
    mem_req_ready = 1;
    check(fin, "R12 result returned", {63'd0, fin}, 64'd1);
  endtask

  initial begin
    logic [63:0] root, va, p1, p2, p3;
    logic [1:0]  acc, priv;
    int mode;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !busy && !rsp_valid && !mem_req_valid, "R12 reset state",
          {60'd0, req_ready, busy, rsp_valid, mem_req_valid}, 64'h8);

    root = 64'h0000_0000_0010_0000;
    // R1 physical index
    run(64'h1234_5678_9ABC_DEF0, 2'd1, 2'd3, root, 0, "R1 physical");
    // R3 superpage with bit 40 set
    run({21'h1FFFFF, 3'b101, 40'h12_3456_7890}, 2'd0, 2'd0, root, 2, "R3 superpage");
    run({21'h1FFFFF, 3'b100, 40'hAB_CDEF_0123}, 2'd2, 2'd0, root, 0, "R3 superpage fetch");
    // R4 superpage from lower privilege
    run({21'h1FFFFF, 3'b101, 40'h12_3456_7890}, 2'd0, 2'd1, root, 0, "R4 superpage user");
    // R2 bad sign extension
    run(64'h0000_1000_0000_0000, 2'd0, 2'd0, root, 0, "R2 sign");
    run(64'hFFFF_F7FF_0000_0000, 2'd1, 2'd2, root, 0, "R2 sign negative");
    // R6 level 1 invalid, level 2 no kernel read
    va = 64'h0000_0123_4567_8000;
    set_walk(va, root, mk(32'h100, KRE), mk(32'h200, V|KRE), mk(32'h300, V|KRE));
    run(va, 2'd0, 2'd0, root, 0, "R6 L1 invalid");
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V), mk(32'h300, V|KRE));
    run(va, 2'd0, 2'd0, root, 1, "R6 L2 no kernel read");
    // R7 leaf invalid
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V|KRE), mk(32'h300, KRE|KWE));
    run(va, 2'd0, 2'd0, root, 0, "R7 leaf invalid");
    // R8 privilege shifted rights
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V|KRE), mk(32'h300, V|KRE));
    run(va, 2'd0, 2'd1, root, 0, "R8 user lacks read");
    run(va, 2'd1, 2'd0, root, 0, "R8 kernel lacks write");
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V|KRE), mk(32'h300, V|ERE));
    run(va, 2'd0, 2'd1, root, 0, "R8 priv 1 read");
    // R10 success with write
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V|KRE), mk(32'hABCDE, V|KRE|KWE));
    run(va, 2'd1, 2'd0, root, 3, "R10 store ok");
    // R9 fault-on codes
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V|KRE), mk(32'h300, V|KRE|KWE|FOE));
    run(va, 2'd2, 2'd0, root, 0, "R9 fault on execute");
    run(va, 2'd0, 2'd0, root, 0, "R9 load with FOE set");
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V|KRE), mk(32'h300, V|KRE|KWE|FOW));
    run(va, 2'd1, 2'd0, root, 0, "R9 fault on write");
    set_walk(va, root, mk(32'h100, V|KRE), mk(32'h200, V|KRE), mk(32'h300, V|KRE|FOR));
    run(va, 2'd0, 2'd0, root, 0, "R9 fault on read");
    run(va, 2'd3, 2'd0, root, 0, "R9 fetch past FOR");

    // Constrained random
    for (int t = 0; t < 400; t++) begin
      mode = $urandom % 8;
      root = {19'd0, 32'($urandom), 13'd0};
      acc  = 2'($urandom);
      priv = 2'($urandom % 3);
      va   = {21'd0, 11'($urandom), 32'($urandom)};
      if ($urandom % 2) begin
        va[63:43] = '1;
        if (va[42:41] == 2'b10) va[41] = 1'b1;
      end
      if (mode == 0) priv = 2'd3;
      else if (mode == 1) begin va[63:43] = '1; va[42:41] = 2'b10; end
      else if (mode == 2) va[50] = ~va[63];
      else begin
        p1 = mk(32'($urandom), ((($urandom % 8) != 0) ? V : 16'h0) | ((($urandom % 8) != 0) ? KRE : 16'h0));
        p2 = mk(32'($urandom), ((($urandom % 8) != 0) ? V : 16'h0) | ((($urandom % 8) != 0) ? KRE : 16'h0));
        p3 = mk(32'($urandom), 16'($urandom) | ((($urandom % 6) != 0) ? V : 16'h0));
        set_walk(va, root, p1, p2, p3);
      end
      run(va, acc, priv, root, int'($urandom % 3), "R8 random walk code");
    end

    all_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule